// File: doc/BRIEF.md
# Two-Term Table Function Approximator

This block evaluates one of four elementary functions of a fixed-point argument for the rotation arithmetic of a matrix triangularisation engine: sine, cosine, arctangent and a square root. The argument is cut into a high field and a low field. The high field selects a table point where both the function value and its first derivative are stored. The result is the stored value plus the derivative scaled by the low field, which is a first-order Taylor step away from that table point.

Both tables are filled while the design elaborates, by constant functions that use integer arithmetic. The datapath has four pipeline registers: argument buffers, table read, a multiplier with round-to-nearest, and a saturating adder. A new argument can enter every cycle. Each argument carries its own function code through the pipe, so the caller can switch functions on every cycle. In square-root mode the argument is taken as y, and the block returns the square root of 1 − y.

Top module: `fapx_top`

## Requirements
- R1: A result leaves with `out_valid` high exactly 4 rising clock edges after the edge that captured `in_valid` high. Arguments with valid set on back-to-back cycles produce results on back-to-back cycles.
- R2: `out_valid` is low while reset is applied and after reset. It stays low in every cycle that does not complete an accepted argument.
- R3: The argument is an unsigned 10-bit fraction x in [0,1). Bits [9:5] give the table point x_H = idx/32, and bits [4:0] give x_L = lo/32, so x = x_H + x_L/32. The output is signed 16-bit with 13 fraction bits. It equals f(x_H) + (x_L/32)·f′(x_H). The derivative product is rounded to nearest before the add, so the output is within 1.1 LSB of that real-valued expression, and within 0.55 LSB when x_L = 0.
- R4: Function code 2'b00 returns sin(x), within 5.5 LSB of the true value over the whole input range.
- R5: Function code 2'b01 returns cos(x), within 5.5 LSB of the true value. For x = 0 it returns exactly 8192.
- R6: Function code 2'b10 returns arctan(x), within 5.5 LSB of the true value. For x = 0 it returns exactly 0.
- R7: Function code 2'b11 takes the argument as y and returns sqrt(1 − y). At table points (low field zero) the result is within 0.55 LSB of the true value, and y = 0 gives exactly 8192.
- R8: The function code is captured together with its argument. A code that changes on every cycle still gives each result the function chosen with its own argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Argument and function code are valid this cycle |
| in_fn | input | 2 | Function code: 00 sine, 01 cosine, 10 arctangent, 11 sqrt(1 − y) |
| in_arg | input | 10 | Unsigned fractional argument |
| out_valid | output | 1 | Result valid this cycle |
| out_data | output | 16 | Signed result, 13 fraction bits |

## Verification
Every argument code is swept for every function and compared with a real-valued linear model. A product that is truncated instead of rounded, or that is shifted by the wrong amount, moves results past the 1.1 LSB bound. Swapped or misindexed tables show up as errors against the true function, most clearly at the exact points x = 0 and at the last table point, where the square-root slope is steepest. Random arguments with random gaps and a function code that changes every cycle catch a code that is not carried with its argument, and catch a valid pipe that is one stage too short or too long.

// File: rtl/fapx_pkg.sv
package fapx_pkg;

  localparam int SC_SH = 30;

  typedef enum logic [1:0] {
    FN_SIN  = 2'b00,
    FN_COS  = 2'b01,
    FN_ATAN = 2'b10,
    FN_SQRT = 2'b11
  } fapx_fn_e;

  function automatic longint fx_mul(input longint a, input longint b);
    return (a * b) >>> SC_SH;
  endfunction

  function automatic longint fx_isqrt(input longint v_in);
    longint v;
    longint res;
    longint bitv;
    v = v_in;
    res = 0;
    bitv = longint'(1) <<< 62;
    while (bitv > v) bitv = bitv >>> 2;
    while (bitv != 0) begin
      if (v >= res + bitv) begin
        v = v - (res + bitv);
        res = (res >>> 1) + bitv;
      end else begin
        res = res >>> 1;
      end
      bitv = bitv >>> 2;
    end
    return res;
  endfunction

  function automatic longint fx_sqrt(input longint x);
    return fx_isqrt(x <<< SC_SH);
  endfunction

  function automatic longint fx_sin(input longint x);
    longint term;
    longint acc;
    term = x;
    acc = x;
    for (int k = 1; k <= 8; k++) begin
      term = -fx_mul(fx_mul(term, x), x) / longint'((2 * k) * (2 * k + 1));
      acc = acc + term;
    end
    return acc;
  endfunction

  function automatic longint fx_cos(input longint x);
    longint term;
    longint acc;
    term = longint'(1) <<< SC_SH;
    acc = term;
    for (int k = 1; k <= 8; k++) begin
      term = -fx_mul(fx_mul(term, x), x) / longint'((2 * k - 1) * (2 * k));
      acc = acc + term;
    end
    return acc;
  endfunction

  function automatic longint fx_atan(input longint x);
    longint one;
    longint u;
    longint u2;
    longint p;
    longint acc;
    one = longint'(1) <<< SC_SH;
    u = (x <<< SC_SH) / (one + fx_sqrt(one + fx_mul(x, x)));
    u2 = fx_mul(u, u);
    p = u;
    acc = u;
    for (int k = 1; k <= 14; k++) begin
      p = fx_mul(p, u2);
      if (k % 2 == 1) acc = acc - p / longint'(2 * k + 1);
      else            acc = acc + p / longint'(2 * k + 1);
    end
    return 2 * acc;
  endfunction

  function automatic longint to_q(input longint v, input int frac, input int dw);
    longint q;
    longint hi;
    int sh;
    sh = SC_SH - frac;
    q = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    hi = (longint'(1) <<< (dw - 1)) - 1;
    if (q > hi) q = hi;
    if (q < -hi - 1) q = -hi - 1;
    return q;
  endfunction

  // Value (deriv = 0) or first derivative (deriv = 1) at table point idx / 2^idx_w.
  function automatic longint tab_entry(input int fn, input int idx, input int idx_w,
                                       input int frac, input int dw, input bit deriv);
    longint one;
    longint x;
    longint r;
    one = longint'(1) <<< SC_SH;
    x = longint'(idx) <<< (SC_SH - idx_w);
    case (fn)
      0:       r = deriv ? fx_cos(x) : fx_sin(x);
      1:       r = deriv ? -fx_sin(x) : fx_cos(x);
      2:       r = deriv ? (one <<< SC_SH) / (one + fx_mul(x, x)) : fx_atan(x);
      default: r = deriv ? -((one <<< SC_SH) / (2 * fx_sqrt(one - x))) : fx_sqrt(one - x);
    endcase
    return to_q(r, frac, dw);
  endfunction

endpackage

// File: rtl/fapx_rom.sv
module fapx_rom #(
  parameter int IDX_W = 5,
  parameter int DAT_W = 16,
  parameter int FRAC  = 13
) (
  input  logic [1:0]              fn,
  input  logic [IDX_W-1:0]        idx,
  output logic signed [DAT_W-1:0] val,
  output logic signed [DAT_W-1:0] der
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NFN   = 4;

  logic signed [DAT_W-1:0] val_tab [NFN][DEPTH];
  logic signed [DAT_W-1:0] der_tab [NFN][DEPTH];

  for (genvar f = 0; f < NFN; f++) begin : g_fn
    for (genvar i = 0; i < DEPTH; i++) begin : g_pt
      localparam logic signed [DAT_W-1:0] VAL_C =
        DAT_W'(fapx_pkg::tab_entry(f, i, IDX_W, FRAC, DAT_W, 1'b0));
      localparam logic signed [DAT_W-1:0] DER_C =
        DAT_W'(fapx_pkg::tab_entry(f, i, IDX_W, FRAC, DAT_W, 1'b1));
      assign val_tab[f][i] = VAL_C;
      assign der_tab[f][i] = DER_C;
    end
  end

  always_comb begin
    val = val_tab[fn][idx];
    der = der_tab[fn][idx];
  end
endmodule

// File: rtl/fapx_mulrnd.sv
module fapx_mulrnd #(
  parameter int DAT_W = 16,
  parameter int LO_W  = 5,
  parameter int SH    = 10
) (
  input  logic                    clk,
  input  logic                    rst_q,
  input  logic                    in_vld,
  input  logic signed [DAT_W-1:0] in_val,
  input  logic signed [DAT_W-1:0] in_der,
  input  logic [LO_W-1:0]         in_lo,
  output logic                    out_vld,
  output logic signed [DAT_W-1:0] out_val,
  output logic signed [DAT_W-1:0] out_prod
);
  localparam int PW = DAT_W + LO_W + 1;
  localparam int RW = PW - SH;
  localparam logic signed [PW-1:0] RND_C = PW'(1) <<< (SH - 1);

  logic signed [PW-1:0]    prod_full;
  logic signed [RW-1:0]    prod_q;
  logic                    vld_d;
  logic signed [DAT_W-1:0] val_d;
  logic signed [DAT_W-1:0] prod_d;

  // next-state
  always_comb begin
    prod_full = PW'(in_der) * $signed({1'b0, in_lo});
    prod_q    = RW'((prod_full + RND_C) >>> SH);
    vld_d     = in_vld;
    val_d     = in_val;
    prod_d    = DAT_W'(prod_q);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_vld <= 1'b0;
    else        out_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_val  <= val_d;
      out_prod <= prod_d;
    end
  end

  function automatic logic [DAT_W:0] mag(input logic signed [DAT_W-1:0] v);
    return v[DAT_W-1] ? (DAT_W+1)'(-$signed({v[DAT_W-1], v})) : (DAT_W+1)'(v);
  endfunction

  AST_RND_BOUND: assert property (@(posedge clk) disable iff (!rst_q)
    in_vld |=> mag(out_prod) <= mag($past(in_der))); // R3
endmodule

// File: rtl/fapx_addsat.sv
module fapx_addsat #(
  parameter int DAT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_q,
  input  logic                    in_vld,
  input  logic signed [DAT_W-1:0] in_val,
  input  logic signed [DAT_W-1:0] in_prod,
  output logic                    out_vld,
  output logic signed [DAT_W-1:0] out_data
);
  localparam logic signed [DAT_W-1:0] MAXV = {1'b0, {(DAT_W-1){1'b1}}};
  localparam logic signed [DAT_W-1:0] MINV = {1'b1, {(DAT_W-1){1'b0}}};

  logic signed [DAT_W:0]   sum;
  logic signed [DAT_W-1:0] sat_d;

  always_comb begin
    sum = {in_val[DAT_W-1], in_val} + {in_prod[DAT_W-1], in_prod};
    if (sum[DAT_W] != sum[DAT_W-1]) sat_d = sum[DAT_W] ? MINV : MAXV;
    else                            sat_d = sum[DAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) out_data <= sat_d;
  end

  AST_ADD_STAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !in_vld |=> !out_vld); // R2
endmodule

// File: rtl/fapx_top.sv
module fapx_top #(
  parameter int ARG_W  = 10,
  parameter int IDX_W  = 5,
  parameter int OUT_W  = 16,
  parameter int OUT_FR = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_fn,
  input  logic [ARG_W-1:0] in_arg,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int LO_W = ARG_W - IDX_W;

  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // stage 1: argument buffers
  logic             s1_vld;
  logic [1:0]       s1_fn;
  logic [IDX_W-1:0] s1_idx;
  logic [LO_W-1:0]  s1_lo;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) s1_vld <= 1'b0;
    else        s1_vld <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_fn  <= in_fn;
      s1_idx <= in_arg[ARG_W-1 -: IDX_W];
      s1_lo  <= in_arg[LO_W-1:0];
    end
  end

  // stage 2: table read
  logic signed [OUT_W-1:0] rom_val, rom_der;
  logic                    s2_vld;
  logic signed [OUT_W-1:0] s2_val, s2_der;
  logic [LO_W-1:0]         s2_lo;

  fapx_rom #(.IDX_W(IDX_W), .DAT_W(OUT_W), .FRAC(OUT_FR)) u_rom (
    .fn  (s1_fn),
    .idx (s1_idx),
    .val (rom_val),
    .der (rom_der)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) s2_vld <= 1'b0;
    else        s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_val <= rom_val;
      s2_der <= rom_der;
      s2_lo  <= s1_lo;
    end
  end

  // stage 3: rounded derivative product
  logic                    s3_vld;
  logic signed [OUT_W-1:0] s3_val, s3_prod;

  fapx_mulrnd #(.DAT_W(OUT_W), .LO_W(LO_W), .SH(ARG_W)) u_mul (
    .clk      (clk),
    .rst_q    (rst_q),
    .in_vld   (s2_vld),
    .in_val   (s2_val),
    .in_der   (s2_der),
    .in_lo    (s2_lo),
    .out_vld  (s3_vld),
    .out_val  (s3_val),
    .out_prod (s3_prod)
  );

  // stage 4: saturating sum
  logic signed [OUT_W-1:0] s4_data;

  fapx_addsat #(.DAT_W(OUT_W)) u_add (
    .clk      (clk),
    .rst_q    (rst_q),
    .in_vld   (s3_vld),
    .in_val   (s3_val),
    .in_prod  (s3_prod),
    .out_vld  (out_valid),
    .out_data (s4_data)
  );

  assign out_data = s4_data;

  AST_LATENCY_HIT: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |-> ##4 out_valid); // R1
  AST_LATENCY_MISS: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |-> ##4 !out_valid); // R2
  AST_RESULT_NONNEG: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> !out_data[OUT_W-1]); // R4
endmodule

// File: tb/fapx_top_test.sv
module fapx_top_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  ARG_W = 10;
  localparam int  IDX_W = 5;
  localparam int  LO_W  = ARG_W - IDX_W;
  localparam int  OUT_W = 16;
  localparam int  OUT_FR = 13;
  localparam real SCALE = 8192.0;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [1:0]       in_fn;
  logic [ARG_W-1:0] in_arg;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  int n_chk;
  int n_fail;

  bit               h_v [4];
  logic [ARG_W-1:0] h_a [4];
  logic [1:0]       h_f [4];
  bit               h_r [4];

  fapx_top #(.ARG_W(ARG_W), .IDX_W(IDX_W), .OUT_W(OUT_W), .OUT_FR(OUT_FR)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_fn     (in_fn),
    .in_arg    (in_arg),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic real f_ref(input logic [1:0] fn, input real x);
    case (fn)
      2'b00:   return $sin(x);
      2'b01:   return $cos(x);
      2'b10:   return $atan(x);
      default: return $sqrt(1.0 - x);
    endcase
  endfunction

  function automatic real d_ref(input logic [1:0] fn, input real x);
    case (fn)
      2'b00:   return $cos(x);
      2'b01:   return -$sin(x);
      2'b10:   return 1.0 / (1.0 + x * x);
      default: return -0.5 / $sqrt(1.0 - x);
    endcase
  endfunction

  function automatic string fn_tag(input logic [1:0] fn);
    case (fn)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic report(input bit ok, input string req, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0f expected=%0f", req, act, exp);
    end
  endtask

  task automatic check_out();
    real xh, xl, x, lin, tru, got, tol;
    string pre;
    pre = h_r[3] ? "R8/" : "";
    report(out_valid === h_v[3], h_v[3] ? {pre, "R1 valid"} : "R2 quiet",
           real'(out_valid), real'(h_v[3]));
    if (h_v[3] && out_valid === 1'b1) begin
      xh  = real'(h_a[3][ARG_W-1 -: IDX_W]) / real'(1 << IDX_W);
      xl  = real'(h_a[3][LO_W-1:0]) / real'(1 << LO_W);
      x   = xh + xl / real'(1 << IDX_W);
      got = real'($signed(out_data));
      lin = (f_ref(h_f[3], xh) + d_ref(h_f[3], xh) * xl / real'(1 << IDX_W)) * SCALE;
      tol = (h_a[3][LO_W-1:0] == '0) ? 0.55 : 1.1;
      report((got - lin <= tol) && (lin - got <= tol), {pre, "R3 linear model"}, got, lin);
      tru = f_ref(h_f[3], x) * SCALE;
      if (h_f[3] != 2'b11) begin
        tol = SCALE / real'(1 << (2 * IDX_W + 1)) + 1.5;
        report((got - tru <= tol) && (tru - got <= tol), {pre, fn_tag(h_f[3])}, got, tru);
      end else if (h_a[3][LO_W-1:0] == '0) begin
        report((got - tru <= 0.55) && (tru - got <= 0.55), {pre, "R7 table point"}, got, tru);
      end
    end
  endtask

  task automatic step(input bit v, input logic [ARG_W-1:0] a, input logic [1:0] f,
                      input bit r);
    @(negedge clk);
    check_out();
    for (int i = 3; i > 0; i--) begin
      h_v[i] = h_v[i-1];
      h_a[i] = h_a[i-1];
      h_f[i] = h_f[i-1];
      h_r[i] = h_r[i-1];
    end
    h_v[0] = v; h_a[0] = a; h_f[0] = f; h_r[0] = r;
    in_valid = v;
    in_arg   = a;
    in_fn    = f;
  endtask

  task automatic exact(input logic [1:0] f, input logic [ARG_W-1:0] a, input int want,
                       input string req);
    step(1'b1, a, f, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 2'b00, 1'b0);
    @(negedge clk);
    report(out_valid === 1'b1 && $signed(out_data) == want, req,
           real'($signed(out_data)), real'(want));
    for (int i = 0; i < 4; i++) begin
      h_v[i] = 1'b0;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    int seed;
    n_chk = 0;
    n_fail = 0;
    for (int i = 0; i < 4; i++) begin
      h_v[i] = 1'b0; h_a[i] = '0; h_f[i] = 2'b00; h_r[i] = 1'b0;
    end
    in_valid = 1'b0;
    in_arg = '0;
    in_fn = 2'b00;
    rst_n = 1'b0;
    seed = $urandom(20240607);
    repeat (4) @(negedge clk);
    report(out_valid === 1'b0, "R2 reset", real'(out_valid), 0.0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report(out_valid === 1'b0, "R2 after reset", real'(out_valid), 0.0);

    exact(2'b01, '0, 8192, "R5 cos(0)");
    exact(2'b10, '0, 0, "R6 atan(0)");
    exact(2'b11, '0, 8192, "R7 sqrt(1-0)");
    exact(2'b00, '0, 0, "R4 sin(0)");

    for (int f = 0; f < 4; f++) begin
      for (int a = 0; a < (1 << ARG_W); a++) begin
        step(1'b1, ARG_W'(a), 2'(f), 1'b0);
      end
    end
    for (int i = 0; i < 6; i++) step(1'b0, '0, 2'b00, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, ARG_W'($urandom), 2'($urandom), 1'b1);
    end
    step(1'b1, '1, 2'b11, 1'b0);
    step(1'b1, '1, 2'b00, 1'b0);
    step(1'b1, '1, 2'b01, 1'b0);
    step(1'b1, '1, 2'b10, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, '0, 2'b00, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule